// File: doc/BRIEF.md
# GPIO Port with Per-Pin Edge Interrupts

This block is a general-purpose I/O port, eight pins wide by default. A small register bus reaches five registers: the output value, the direction, the interrupt enable, the edge polarity and the edge flags. A pin whose direction bit is set drives the stored output value. A pin whose direction bit is clear is sampled through a synchronizer. A read of the data register returns the stored bit for output pins and the synchronized pin level for input pins.

Each pin has an edge detector. The detector watches the level actually present on the pin. For an output pin this is the level the port drives itself, and for an input pin it is the external level. When the edge chosen by that pin's polarity bit occurs, the pin's flag is set. Software clears a flag by writing a one to it. One combined interrupt request is asserted, one cycle after the fact, whenever any pin has both its flag and its enable set.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset all five registers read 0, `pin_oe` and `pin_out` are 0, and `irq` is 0.
- R2: `pin_oe[i]` equals direction bit i. `pin_out` equals the data register. A write to address 1 (direction) takes effect on `pin_oe` at the next clock edge.
- R3: A read of address 0 returns, for bit i, the data register bit when direction bit i is 1, and the synchronized `pin_in[i]` when it is 0.
- R4: Polarity bit i set to 1 selects the rising edge and 0 selects the falling edge. Only the selected edge sets flag i, and the opposite edge leaves it unchanged.
- R5: Writing address 4 clears each flag bit written as 1 and leaves each flag bit written as 0 unchanged.
- R6: When an active edge and a write-one-to-clear reach the same flag bit in the same cycle, the flag stays set.
- R7: A flag is set on its active edge even while its enable bit is 0, and `irq` stays 0 in that case.
- R8: `irq` is the OR over all pins of (flag AND enable), registered, so it follows a change of flag or enable by one clock.
- R9: For an output pin, edges come from the driven data bit. `pin_in` changes on that pin set no flag and do not affect the data read.
- R10: Address map: 0 data, 1 direction, 2 enable, 3 polarity, 4 flags. Read data appears on `bus_rdata` one clock after the `bus_rd` strobe. Addresses 5 to 7 read as 0, and writes to them change no register.
- R11: A change on an input pin sets its flag on the third clock edge after the change, counting two synchronizer stages and one compare stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Driven pin values |
| pin_oe | output | 8 | Per-pin output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the port with its default values: eight pins, a two-stage synchronizer and a registered interrupt output. With eight pins, the mixed-direction read, the per-pin polarity choice and the per-pin clear masks can each be exercised on different bits of the same word. The two-stage synchronizer gives the exact three-edge latency, which the bench uses to make an edge and a clear land on the same cycle. With the three-bit address, the unmapped addresses 5 to 7 are reachable from the bus.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int unsigned REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      SEL_DATA = 3'd0,
      SEL_DIR  = 3'd1,
      SEL_IEN  = 3'd2,
      SEL_POL  = 3'd3,
      SEL_FLAG = 3'd4
   } reg_sel_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_irq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[LAST];

endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] pol,
   input  logic [WIDTH-1:0] clr,
   output logic [WIDTH-1:0] flags
);

   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] flags_q;
   logic [WIDTH-1:0] evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_det
      logic rise, fall;
      assign rise   = level[i] & ~prev_q[i];
      assign fall   = ~level[i] & prev_q[i];
      assign evt[i] = pol[i] ? rise : fall;

      // edge wins over a simultaneous clear (R6)
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      flags_q[i] <= 1'b0;
         else if (evt[i]) flags_q[i] <= 1'b1;
         else if (clr[i]) flags_q[i] <= 1'b0;
      end
   end

   assign flags = flags_q;

   a_r4_edge_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((flags_q & $past(evt)) == $past(evt)));

   a_r4_no_set_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (evt == '0) |=> ((flags_q & ~$past(flags_q)) == '0));

   a_r5_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & ~evt) != '0) |=> ((flags_q & $past(clr & ~evt)) == '0));

   a_r6_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr & evt) != '0) |=> ((flags_q & $past(clr & evt)) == $past(clr & evt)));

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [WIDTH-1:0]      bus_wdata,
   output logic [WIDTH-1:0]      bus_rdata,
   input  logic [WIDTH-1:0]      flags,
   input  logic [WIDTH-1:0]      pin_level,
   output logic [WIDTH-1:0]      data_q,
   output logic [WIDTH-1:0]      dir_q,
   output logic [WIDTH-1:0]      ien_q,
   output logic [WIDTH-1:0]      pol_q,
   output logic [WIDTH-1:0]      flag_clr
);

   reg_sel_e         sel;
   logic [WIDTH-1:0] data_view;
   logic [WIDTH-1:0] rd_mux;
   logic [WIDTH-1:0] rdata_q;

   assign sel = reg_sel_e'(bus_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
         ien_q  <= '0;
         pol_q  <= '0;
      end else if (bus_wr) begin
         case (sel)
            SEL_DATA: data_q <= bus_wdata;
            SEL_DIR:  dir_q  <= bus_wdata;
            SEL_IEN:  ien_q  <= bus_wdata;
            SEL_POL:  pol_q  <= bus_wdata;
            default:  ;
         endcase
      end
   end

   assign flag_clr = (bus_wr && sel == SEL_FLAG) ? bus_wdata : '0;

   for (genvar i = 0; i < WIDTH; i++) begin : g_view
      assign data_view[i] = dir_q[i] ? data_q[i] : pin_level[i];
   end

   always_comb begin
      case (sel)
         SEL_DATA: rd_mux = data_view;
         SEL_DIR:  rd_mux = dir_q;
         SEL_IEN:  rd_mux = ien_q;
         SEL_POL:  rd_mux = pol_q;
         SEL_FLAG: rd_mux = flags;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;

   a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd1) |=> (dir_q == $past(bus_wdata)));

   a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr > 3'd4) |=>
         ($stable(data_q) && $stable(dir_q) && $stable(ien_q) && $stable(pol_q)));

   a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr > 3'd4) |=> (bus_rdata == '0));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IRQ_REG     = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic                  bus_wr,
   input  logic                  bus_rd,
   input  logic [WIDTH-1:0]      bus_wdata,
   output logic [WIDTH-1:0]      bus_rdata,
   input  logic [WIDTH-1:0]      pin_in,
   output logic [WIDTH-1:0]      pin_out,
   output logic [WIDTH-1:0]      pin_oe,
   output logic                  irq
);

   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("gpio_irq_port: WIDTH must lie in 1..32");
   end

   logic [WIDTH-1:0] data_q, dir_q, ien_q, pol_q;
   logic [WIDTH-1:0] flag_clr, flags;
   logic [WIDTH-1:0] pad_level, synced;
   logic             irq_any;

   // edge source: driven value for outputs, external level for inputs (R9)
   for (genvar i = 0; i < WIDTH; i++) begin : g_pad
      assign pad_level[i] = dir_q[i] ? data_q[i] : pin_in[i];
   end

   gpio_irq_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_level),
      .q     (synced)
   );

   gpio_irq_edge #(.WIDTH(WIDTH)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (synced),
      .pol   (pol_q),
      .clr   (flag_clr),
      .flags (flags)
   );

   gpio_irq_regs #(.WIDTH(WIDTH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .flags     (flags),
      .pin_level (synced),
      .data_q    (data_q),
      .dir_q     (dir_q),
      .ien_q     (ien_q),
      .pol_q     (pol_q),
      .flag_clr  (flag_clr)
   );

   assign irq_any = |(flags & ien_q);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_any;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_any;
   end

   assign pin_out = data_q;
   assign pin_oe  = dir_q;

   a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & ien_q) == '0) |=> !irq);

   a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0) |=> !irq);

endmodule

// File: tb/gpio_irq_port_bench.sv
module gpio_irq_port_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = '0;
   logic [7:0] pin_out, pin_oe;
   logic       irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_port u_gpio_irq_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R1 pin_oe", pin_oe, 8'h00);
      check("R1 pin_out", pin_out, 8'h00);
      check("R1 irq", {7'd0, irq}, 8'h00);
      for (int a = 1; a < 5; a++) begin
         rd(a[2:0], v);
         check("R1 reg reset", v, 8'h00);
      end
   endtask

   task automatic t_direction_and_read();
      logic [7:0] v;
      wr(3'd0, 8'hA5);
      wr(3'd1, 8'h0F);
      check("R2 pin_oe", pin_oe, 8'h0F);
      check("R2 pin_out", pin_out, 8'hA5);
      pin_in = 8'h3C;
      settle();
      rd(3'd0, v);
      check("R3 mixed data read", v, 8'h35);
      rd(3'd1, v);
      check("R10 dir readback", v, 8'h0F);
      wr(3'd1, 8'h00);
      wr(3'd4, 8'hFF);
   endtask

   task automatic t_polarity();
      logic [7:0] v;
      pin_in = 8'h00; settle();
      wr(3'd3, 8'h01);
      wr(3'd4, 8'hFF);
      pin_in = 8'h03; settle();
      rd(3'd4, v);
      check("R4 rising only on bit0", v, 8'h01);
      pin_in = 8'h00; settle();
      rd(3'd4, v);
      check("R4 falling on bit1", v, 8'h03);
      wr(3'd4, 8'h02);
      rd(3'd4, v);
      check("R5 w1c bit1, bit0 kept", v, 8'h01);
      wr(3'd4, 8'h00);
      rd(3'd4, v);
      check("R5 write zero no effect", v, 8'h01);
      wr(3'd4, 8'h01);
      rd(3'd4, v);
      check("R5 cleared", v, 8'h00);
   endtask

   task automatic t_latency();
      logic [7:0] v;
      wr(3'd3, 8'h04);
      @(negedge clk); pin_in = 8'h04;
      @(negedge clk); @(negedge clk);
      bus_rd = 1'b1; bus_addr = 3'd4;
      @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
      check("R11 not yet after two edges", v, 8'h00);
      rd(3'd4, v);
      check("R11 set on third edge", v, 8'h04);
      wr(3'd4, 8'hFF);
      pin_in = 8'h00; settle();
   endtask

   task automatic t_collision();
      logic [7:0] v;
      wr(3'd3, 8'h10);
      pin_in = 8'h10; settle();
      pin_in = 8'h00; settle();
      @(negedge clk); pin_in = 8'h10;
      @(negedge clk); @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'd4; bus_wdata = 8'h10;
      @(negedge clk); bus_wr = 1'b0;
      rd(3'd4, v);
      check("R6 edge beats clear", v, 8'h10);
      wr(3'd4, 8'hFF);
      pin_in = 8'h00; settle();
   endtask

   task automatic t_irq();
      logic [7:0] v;
      wr(3'd3, 8'h20);
      pin_in = 8'h20; settle();
      rd(3'd4, v);
      check("R7 flag with enable off", v, 8'h20);
      check("R7 irq low", {7'd0, irq}, 8'h00);
      @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h20;
      @(negedge clk); bus_wr = 1'b0;
      check("R8 irq one cycle late", {7'd0, irq}, 8'h00);
      @(negedge clk);
      check("R8 irq high", {7'd0, irq}, 8'h01);
      wr(3'd4, 8'h20);
      @(negedge clk);
      check("R8 irq drops after clear", {7'd0, irq}, 8'h00);
      wr(3'd2, 8'h00);
      pin_in = 8'h00; settle();
   endtask

   task automatic t_output_mode();
      logic [7:0] v;
      wr(3'd3, 8'h40);
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h40);
      settle();
      wr(3'd4, 8'hFF);
      pin_in = 8'h40; settle();
      rd(3'd4, v);
      check("R9 pin_in ignored on output", v, 8'h00);
      rd(3'd0, v);
      check("R9 data read uses register", v & 8'h40, 8'h00);
      wr(3'd0, 8'h40); settle();
      rd(3'd4, v);
      check("R9 driven edge sets flag", v, 8'h40);
      wr(3'd1, 8'h00); wr(3'd0, 8'h00);
      pin_in = 8'h00; settle();
      wr(3'd4, 8'hFF); wr(3'd3, 8'h00);
   endtask

   task automatic t_unmapped();
      logic [7:0] v;
      wr(3'd2, 8'h5A);
      for (int a = 5; a < 8; a++) begin
         wr(a[2:0], 8'hFF);
         rd(a[2:0], v);
         check("R10 unmapped reads zero", v, 8'h00);
      end
      rd(3'd2, v);
      check("R10 enable untouched", v, 8'h5A);
      check("R10 oe untouched", pin_oe, 8'h00);
      rd(3'd0, v);
      check("R10 data untouched", v, 8'h00);
      wr(3'd2, 8'h00);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direction_and_read();
      t_polarity();
      t_latency();
      t_collision();
      t_irq();
      t_output_mode();
      t_unmapped();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule